// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the minimum-mode bus interface of a processor whose address and data share one set of lines. The core hands it one transfer at a time. Each transfer is a read or a write, to memory or to I/O, and carries a 20-bit address, an upper-byte request, four status bits and write data. The block turns the transfer into a bus cycle of at least four clocks, called T1, T2, T3 and T4. In T1 the shared lines carry the address, and the latch strobe tells external latches to capture it. From T2 on, the same lines carry write data or are released so that read data can come in. The four highest address lines switch over to the status bits.

External logic lengthens a cycle by holding `ready` low. The block samples `ready` when T2 ends and again at the end of every wait state. Until it sees `ready` high it stays in wait states, with the strobes held asserted. Read data is captured as T3 closes. T3 always follows the last wait state. One clock after T4 the core gets a single-cycle `done` pulse together with the captured data. A new request presented during T4 starts its own T1 straight away, with no idle clock in between.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held and in idle: `ale`=0, `ad_oe`=0, `ad_out`=0, `as_out`=0, `rd_n`=1, `wr_n`=1, `den_n`=1, `dt_r`=0, `mio`=0, `bhe_n`=1, `done`=0, `req_ready`=1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. The next cycle is T1, which lasts exactly one clock. In T1: `ale`=1, `ad_oe`=1, `ad_out`=address bits 15..0, `as_out`=address bits 19..16, `den_n`=1, and `rd_n` and `wr_n` are both 1.
- R3: From T2 through T4, `ale`=0 and `as_out` carries the request's four status bits in place of the address bits.
- R4: On a read (`req_write`=0), `ad_oe`=0 from T2 through T4. `rd_n`=0 in T2, in every wait state and in T3, and `rd_n`=1 in T4. `wr_n` stays 1 and `dt_r` stays 0.
- R5: On a write (`req_write`=1), `ad_oe`=1 and `ad_out`=write data from T2 through T4. `wr_n`=0 in T2, in every wait state and in T3, and `wr_n`=1 in T4. `rd_n` stays 1, and `dt_r`=1 from T1 through T4.
- R6: `den_n`=0 in T2, in wait states and in T3. In T4, `den_n` is 0 on writes and 1 on reads.
- R7: From T1 through T4, `mio` is the inverse of `req_io` (1 means a memory address) and `bhe_n` is the inverse of `req_hi`.
- R8: `ready` is sampled at the end of T2 and at the end of every wait state. Each low sample adds one wait-state clock, so a cycle with N low samples lasts 4+N clocks. `ready` has no effect in any other cycle.
- R9: On a read, `ad_in` is captured at the end of T3. In the clock after T4, `done`=1 for exactly one cycle and `rdata` shows the captured value. A write also raises `done`, but `rdata` keeps the value from the last read.
- R10: `req_ready` is 1 only in idle and in T4. A request accepted in T4 puts the block in T1 on the next clock. In T1 through T3 and in wait states, `req_valid` and the request fields are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core presents a transfer |
| req_ready | output | 1 | Block can accept a transfer this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O port, 0 = memory |
| req_hi | input | 1 | Upper data byte takes part |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_stat | input | 4 | Status bits shown on the upper lines after T1 |
| ready | input | 1 | Wait-state control, low extends the cycle |
| ad_in | input | 16 | Shared lines, value received from the bus |
| ad_out | output | 16 | Shared lines, value driven |
| ad_oe | output | 1 | Drive enable for the shared lines |
| as_out | output | 4 | Upper address / status lines |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dt_r | output | 1 | Buffer direction, 1 transmit, 0 receive |
| den_n | output | 1 | Buffer enable, active low |
| mio | output | 1 | 1 memory cycle, 0 I/O cycle |
| bhe_n | output | 1 | Upper byte enable, active low |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |

## Verification
The bench builds the block with its default widths: a 20-bit address and 16-bit data, which leaves four shared address/status lines and one upper byte lane. Random transfers use 0 to 3 wait states, and directed cases go up to 5. Chaining in T4 is mixed in, so T4-to-T1 turnarounds are covered in both directions (read to write and write to read). `ad_in` is set to the expected read value only during T3 and carries junk in the wait states. A capture taken one clock early or late therefore shows up in `rdata`.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_e;
endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int STAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_hi,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [STAT_W-1:0] req_stat,
    input  logic              ready,
    output phase_e            phase,
    output logic              req_ready,
    output logic              cur_write,
    output logic              cur_io,
    output logic              cur_hi,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic [STAT_W-1:0] cur_stat
);
    typedef struct packed {
        phase_e              phase;
        logic                write;
        logic                io;
        logic                hi;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [STAT_W-1:0]   stat;
    } seq_s;

    seq_s seq_d, seq_q;
    logic open_d;

    always_comb begin
        seq_d  = seq_q;
        open_d = (seq_q.phase == PH_IDLE) || (seq_q.phase == PH_T4);
        case (seq_q.phase)
            PH_IDLE: seq_d.phase = PH_IDLE;
            PH_T1:   seq_d.phase = PH_T2;
            PH_T2:   seq_d.phase = ready ? PH_T3 : PH_TW;
            PH_TW:   seq_d.phase = ready ? PH_T3 : PH_TW;
            PH_T3:   seq_d.phase = PH_T4;
            PH_T4:   seq_d.phase = PH_IDLE;
            default: seq_d.phase = PH_IDLE;
        endcase
        if (open_d && req_valid) begin
            seq_d.phase = PH_T1;
            seq_d.write = req_write;
            seq_d.io    = req_io;
            seq_d.hi    = req_hi;
            seq_d.addr  = req_addr;
            seq_d.wdata = req_wdata;
            seq_d.stat  = req_stat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign phase     = seq_q.phase;
    assign req_ready = open_d;
    assign cur_write = seq_q.write;
    assign cur_io    = seq_q.io;
    assign cur_hi    = seq_q.hi;
    assign cur_addr  = seq_q.addr;
    assign cur_wdata = seq_q.wdata;
    assign cur_stat  = seq_q.stat;

    // R2
    t1_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_T1) |=> (seq_q.phase == PH_T2));
    // R8
    wait_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_T2 && !ready) |=> (seq_q.phase == PH_TW));
    // R8
    wait_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_TW && ready) |=> (seq_q.phase == PH_T3));
    // R10
    chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_T4 && req_valid) |=> (seq_q.phase == PH_T1));
    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_T3) |=> (seq_q.phase == PH_T4));
endmodule

// File: rtl/bcs_drive.sv
module bcs_drive
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int STAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              cur_write,
    input  logic              cur_io,
    input  logic              cur_hi,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] cur_wdata,
    input  logic [STAT_W-1:0] cur_stat,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [STAT_W-1:0] as_out,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              dt_r,
    output logic              den_n,
    output logic              mio,
    output logic              bhe_n
);
    typedef struct packed {
        logic [DATA_W-1:0] ad;
        logic              oe;
        logic [STAT_W-1:0] as;
        logic              ale;
        logic              rd_n;
        logic              wr_n;
        logic              dt_r;
        logic              den_n;
        logic              mio;
        logic              bhe_n;
    } pins_s;

    pins_s pins_d;
    logic  strobe_d;
    logic  active_d;

    always_comb begin
        active_d = (phase != PH_IDLE);
        strobe_d = (phase == PH_T2) || (phase == PH_TW) || (phase == PH_T3);
        pins_d   = '0;
        pins_d.rd_n  = 1'b1;
        pins_d.wr_n  = 1'b1;
        pins_d.den_n = 1'b1;
        pins_d.bhe_n = 1'b1;
        if (active_d) begin
            pins_d.dt_r  = cur_write;
            pins_d.mio   = ~cur_io;
            pins_d.bhe_n = ~cur_hi;
            if (phase == PH_T1) begin
                pins_d.ale = 1'b1;
                pins_d.oe  = 1'b1;
                pins_d.ad  = cur_addr[DATA_W-1:0];
                pins_d.as  = cur_addr[ADDR_W-1:DATA_W];
            end else begin
                pins_d.as    = cur_stat;
                pins_d.oe    = cur_write;
                pins_d.ad    = cur_write ? cur_wdata : '0;
                pins_d.rd_n  = ~(strobe_d && !cur_write);
                pins_d.wr_n  = ~(strobe_d && cur_write);
                pins_d.den_n = ~(strobe_d || cur_write);
            end
        end
    end

    assign ad_out = pins_d.ad;
    assign ad_oe  = pins_d.oe;
    assign as_out = pins_d.as;
    assign ale    = pins_d.ale;
    assign rd_n   = pins_d.rd_n;
    assign wr_n   = pins_d.wr_n;
    assign dt_r   = pins_d.dt_r;
    assign den_n  = pins_d.den_n;
    assign mio    = pins_d.mio;
    assign bhe_n  = pins_d.bhe_n;

    // R4
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (!ad_oe && !dt_r && !den_n));
    // R5
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (ad_oe && dt_r && !den_n));
    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || wr_n));
    // R2
    ale_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && den_n && rd_n && wr_n));
    // R3
    ale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
endmodule

// File: rtl/bcs_capture.sv
module bcs_capture
    import bcs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              cur_write,
    input  logic [DATA_W-1:0] ad_in,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic              done;
        logic [DATA_W-1:0] rdata;
    } cap_s;

    cap_s cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.done = (phase == PH_T4);
        if (phase == PH_T3 && !cur_write)
            cap_d.rdata = ad_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign done  = cap_q.done;
    assign rdata = cap_q.rdata;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_T3) |=> $stable(rdata));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_hi,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [ADDR_W-DATA_W-1:0] req_stat,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] as_out,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              dt_r,
    output logic              den_n,
    output logic              mio,
    output logic              bhe_n,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int STAT_W = ADDR_W - DATA_W;

    phase_e            phase;
    logic              cur_write, cur_io, cur_hi;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic [STAT_W-1:0] cur_stat;

    bcs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_write(req_write), .req_io(req_io), .req_hi(req_hi),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_stat(req_stat),
        .ready(ready), .phase(phase), .req_ready(req_ready),
        .cur_write(cur_write), .cur_io(cur_io), .cur_hi(cur_hi),
        .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_stat(cur_stat)
    );

    bcs_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_drive (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .cur_write(cur_write), .cur_io(cur_io), .cur_hi(cur_hi),
        .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_stat(cur_stat),
        .ad_out(ad_out), .ad_oe(ad_oe), .as_out(as_out), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .dt_r(dt_r), .den_n(den_n),
        .mio(mio), .bhe_n(bhe_n)
    );

    bcs_capture #(.DATA_W(DATA_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cur_write(cur_write),
        .ad_in(ad_in), .done(done), .rdata(rdata)
    );
endmodule

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit          write;
        bit          io;
        bit          hi;
        logic [19:0] addr;
        logic [15:0] wdata;
        logic [3:0]  stat;
        int          nwait;
        logic [15:0] rdval;
    } op_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, req_hi = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  req_stat = '0;
    logic        ready = 1'b1;
    logic [15:0] ad_in = '0;
    logic        req_ready, ad_oe, ale, rd_n, wr_n, dt_r, den_n, mio, bhe_n, done;
    logic [15:0] ad_out, rdata;
    logic [3:0]  as_out;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;
    logic [15:0] exp_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_io(req_io), .req_hi(req_hi),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_stat(req_stat),
        .ready(ready), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .as_out(as_out), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .dt_r(dt_r),
        .den_n(den_n), .mio(mio), .bhe_n(bhe_n), .done(done), .rdata(rdata)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic op_t rand_op();
        op_t o;
        logic [31:0] r;
        r = $urandom; o.addr  = r[19:0];
        r = $urandom; o.wdata = r[15:0]; o.rdval = r[31:16];
        r = $urandom; o.write = r[0]; o.io = r[1]; o.hi = r[2]; o.stat = r[7:4];
        o.nwait = int'(r[9:8]);
        return o;
    endfunction

    task automatic drive_req(input op_t o);
        req_valid = 1'b1; req_write = o.write; req_io = o.io; req_hi = o.hi;
        req_addr = o.addr; req_wdata = o.wdata; req_stat = o.stat;
    endtask

    task automatic drive_junk();
        logic [31:0] r;
        r = $urandom;
        req_valid = 1'b1; req_write = r[0]; req_io = r[1]; req_hi = r[2];
        req_addr = r[31:12]; req_wdata = r[15:0]; req_stat = r[7:4];
        r = $urandom; ad_in = r[15:0];
    endtask

    task automatic check_idle(input string tag);
        chk(tag, "ale", ale, 0);       chk(tag, "ad_oe", ad_oe, 0);
        chk(tag, "ad_out", ad_out, 0); chk(tag, "as_out", as_out, 0);
        chk(tag, "rd_n", rd_n, 1);     chk(tag, "wr_n", wr_n, 1);
        chk(tag, "den_n", den_n, 1);   chk(tag, "dt_r", dt_r, 0);
        chk(tag, "mio", mio, 0);       chk(tag, "bhe_n", bhe_n, 1);
        chk(tag, "done", done, 0);     chk(tag, "req_ready", req_ready, 1);
    endtask

    // ph: 1 = T1, 2 = strobe phase (T2, wait, T3), 4 = T4
    task automatic check_bus(input op_t o, input int ph);
        chk("R7", "mio", mio, {31'b0, ~o.io});
        chk("R7", "bhe_n", bhe_n, {31'b0, ~o.hi});
        chk(o.write ? "R5" : "R4", "dt_r", dt_r, {31'b0, o.write});
        if (ph == 1) begin
            chk("R2", "ale", ale, 1);       chk("R2", "ad_oe", ad_oe, 1);
            chk("R2", "ad_out", ad_out, {16'b0, o.addr[15:0]});
            chk("R2", "as_out", as_out, {28'b0, o.addr[19:16]});
            chk("R2", "den_n", den_n, 1);
            chk("R2", "rd_n", rd_n, 1);     chk("R2", "wr_n", wr_n, 1);
        end else begin
            chk("R3", "ale", ale, 0);
            chk("R3", "as_out", as_out, {28'b0, o.stat});
            if (o.write) begin
                chk("R5", "ad_oe", ad_oe, 1);
                chk("R5", "ad_out", ad_out, {16'b0, o.wdata});
                chk("R5", "rd_n", rd_n, 1);
                chk("R5", "wr_n", wr_n, (ph == 4) ? 1 : 0);
                chk("R6", "den_n", den_n, 0);
            end else begin
                chk("R4", "ad_oe", ad_oe, 0);
                chk("R4", "wr_n", wr_n, 1);
                chk("R4", "rd_n", rd_n, (ph == 4) ? 1 : 0);
                chk("R6", "den_n", den_n, (ph == 4) ? 1 : 0);
            end
        end
    endtask

    // accepted = 1: request was taken in the previous T4, now at T1 negedge
    task automatic bus_op(input op_t o, input bit accepted, input bit chain, input op_t nxt);
        if (!accepted) begin
            @(negedge clk);
            chk("R10", "req_ready idle", req_ready, 1);
            drive_req(o);
            @(negedge clk);
        end
        req_valid = 1'b0;
        check_bus(o, 1);
        chk("R10", "req_ready T1", req_ready, 0);
        drive_junk();
        @(negedge clk);
        check_bus(o, 2);
        chk("R10", "req_ready T2", req_ready, 0);
        drive_junk();
        ready = (o.nwait == 0);
        for (int i = 0; i < o.nwait; i++) begin
            @(negedge clk);
            check_bus(o, 2);
            chk("R8", "req_ready wait", req_ready, 0);
            drive_junk();
            ready = (i == o.nwait - 1);
        end
        @(negedge clk);
        check_bus(o, 2);
        drive_junk();
        ad_in = o.rdval;
        ready = $urandom_range(0, 1) != 0;
        @(negedge clk);
        check_bus(o, 4);
        chk("R8", "rd_n/wr_n released at T4", {30'b0, rd_n, wr_n}, 32'h3);
        chk("R10", "req_ready T4", req_ready, 1);
        chk("R9", "done before end", done, 0);
        ad_in = 16'hdead;
        if (chain) drive_req(nxt);
        else req_valid = 1'b0;
        @(negedge clk);
        if (!o.write) exp_rd = o.rdval;
        chk("R9", "done", done, 1);
        chk("R9", "rdata", rdata, {16'b0, exp_rd});
        if (!chain) begin
            @(negedge clk);
            check_idle("R1");
            chk("R9", "rdata hold", rdata, {16'b0, exp_rd});
        end
    endtask

    op_t dummy;

    initial begin
        op_t a, b, cur, nxt;
        bit acc, ch;
        void'($urandom(32'h1dc0ffee));
        dummy = rand_op();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        // directed: read, no wait
        a = rand_op(); a.write = 0; a.io = 0; a.hi = 1; a.nwait = 0; a.rdval = 16'h1234;
        bus_op(a, 0, 0, dummy);
        // directed: I/O write, low byte only, no wait
        a = rand_op(); a.write = 1; a.io = 1; a.hi = 0; a.nwait = 0;
        bus_op(a, 0, 0, dummy);
        // directed: read with 5 waits
        a = rand_op(); a.write = 0; a.nwait = 5; a.rdval = 16'hbeef;
        bus_op(a, 0, 0, dummy);
        // directed: write with 1 wait, chained into read with 2 waits
        a = rand_op(); a.write = 1; a.nwait = 1;
        b = rand_op(); b.write = 0; b.nwait = 2; b.rdval = 16'h5a5a;
        bus_op(a, 0, 1, b);
        bus_op(b, 1, 0, dummy);
        // directed: read chained into write
        a = rand_op(); a.write = 0; a.nwait = 0; a.rdval = 16'hc3c3;
        b = rand_op(); b.write = 1; b.nwait = 3;
        bus_op(a, 0, 1, b);
        bus_op(b, 1, 0, dummy);

        // random
        cur = rand_op(); acc = 0;
        for (int i = 0; i < 60; i++) begin
            nxt = rand_op();
            ch = (i < 59) && ($urandom_range(0, 3) == 0);
            bus_op(cur, acc, ch, nxt);
            acc = ch;
            cur = nxt;
        end

        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule